// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell software which kind of reset brought the chip back up. There are four causes: power-on, external pin, supply brown-out and watchdog. Each has one flag bit. Once a flag is set it stays set until software clears it on purpose. A boot routine reads the register first. It then writes zeros to the flags it has handled, so that whatever sets a flag afterwards can be told apart from the reset that has just happened.

Power-on is the master event. It arrives as an asynchronous active-low input. While that input is low, the register holds a value with only the power-on flag set, so all the other causes are erased. The external, brown-out and watchdog causes arrive as single-cycle pulses, synchronous to the clock, from the reset generation logic. The watchdog flag is also driven out on its own pin, so that a companion watchdog controller can use it.

The block has no state machine. Each flag is an independent sticky cell, and the read path pads the four flags with zeros up to the data width.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_n` is low the register reads 0x01 at once, without a clock edge: the power-on flag is set and every other flag is cleared.
- R2: Bits 7 to 4 of `rd_data` always read zero, whatever value was written to them.
- R3: The flag positions are fixed: bit 3 is the watchdog cause, bit 2 the brown-out cause, bit 1 the external cause and bit 0 the power-on cause.
- R4: A high pulse on `evt_ext`, `evt_brown` or `evt_wdog` during one clock cycle sets the matching flag, and the flag is visible after that rising edge.
- R5: A write (`wr_en` high) with a zero in a flag's bit position clears that flag on the same rising edge.
- R6: A write with a one in a flag's bit position leaves that flag unchanged.
- R7: If a cause pulse and a clearing write to the same flag happen in the same cycle, the flag ends up set.
- R8: Once `por_n` is high, the power-on flag can only be cleared by writing a zero to bit 0, and no synchronous cause pulse ever sets it.
- R9: With no write and no cause pulse, every flag keeps its value from one cycle to the next.
- R10: `wdog_flag` always equals bit 3 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on event, active low |
| evt_ext | input | 1 | External reset cause pulse, one cycle |
| evt_brown | input | 1 | Brown-out reset cause pulse, one cycle |
| evt_wdog | input | 1 | Watchdog reset cause pulse, one cycle |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 8 | Write value; a zero clears a flag, a one keeps it |
| rd_data | output | 8 | Current register value |
| wdog_flag | output | 1 | Watchdog cause flag, for the watchdog controller |

## Verification
Some rules are checked by the assertions on every clock: a pulse sets its flag, a clearing write clears it unless a pulse hits the same flag, a write of one and an idle cycle both leave a flag unchanged, the power-on flag never rises after power-on has ended, the reserved bits stay zero and the watchdog pin follows bit 3. Other behaviour can only be shown by the bench's scenarios. These are the asynchronous load to 0x01 in the middle of a run, the interplay of many random writes with sparse cause pulses over time, and each cause pulse landing at its documented bit position.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int unsigned RCS_DATA_W = 8;
    localparam int unsigned RCS_FLAG_W = 4;

    // Bit positions, decoded by software and by the watchdog controller
    localparam int unsigned POS_PWR   = 0;
    localparam int unsigned POS_EXT   = 1;
    localparam int unsigned POS_BROWN = 2;
    localparam int unsigned POS_WDOG  = 3;

    // Value loaded while power-on is active
    localparam logic [RCS_FLAG_W-1:0] RCS_PWR_VAL = RCS_FLAG_W'(1) << POS_PWR;
endpackage

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell #(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    logic q;
    logic q_nxt;

    // Set dominates; a write keeps the flag only where the written bit is one
    always_comb begin
        q_nxt = wr_en_i ? (q & wr_bit_i) : q;
        if (set_i) begin
            q_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= INIT_VAL;
        end else begin
            q <= q_nxt;
        end
    end

    assign flag_o = q;

    // R4, R7
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_i |=> flag_o);

    // R5
    zero_write_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en_i && !wr_bit_i && !set_i) |=> !flag_o);

    // R6
    one_write_keeps_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en_i && wr_bit_i && !set_i) |=> $stable(flag_o));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/rcs_read_fmt.sv
module rcs_read_fmt #(
    parameter int unsigned FLAG_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] rd_o
);
    localparam int unsigned PAD_W = DATA_W - FLAG_W;

    always_comb begin
        rd_o = {{PAD_W{1'b0}}, flags_i};
    end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import rcs_pkg::*;
#(
    parameter int unsigned DATA_W = RCS_DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              evt_ext,
    input  logic              evt_brown,
    input  logic              evt_wdog,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdog_flag
);
    localparam int unsigned FLAG_W = RCS_FLAG_W;

    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:FLAG_W];

    // Power-on has no synchronous set path; it only acts through por_n
    always_comb begin
        set_vec            = '0;
        set_vec[POS_EXT]   = evt_ext;
        set_vec[POS_BROWN] = evt_brown;
        set_vec[POS_WDOG]  = evt_wdog;
    end

    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
        rcs_flag_cell #(
            .INIT_VAL (RCS_PWR_VAL[gi])
        ) u_cell (
            .clk      (clk),
            .por_n    (por_n),
            .set_i    (set_vec[gi]),
            .wr_en_i  (wr_en),
            .wr_bit_i (wr_data[gi]),
            .flag_o   (flags[gi])
        );
    end

    rcs_read_fmt #(
        .FLAG_W (FLAG_W),
        .DATA_W (DATA_W)
    ) u_fmt (
        .flags_i (flags),
        .rd_o    (rd_data)
    );

    assign wdog_flag = flags[POS_WDOG];

    // R8
    pwr_flag_no_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(rd_data[POS_PWR]));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[DATA_W-1:FLAG_W] == '0);

    // R10
    wdog_mirror_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdog_flag == rd_data[POS_WDOG]);
endmodule

// File: tb/reset_cause_reg_tb.sv
module reset_cause_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       evt_ext = 1'b0;
    logic       evt_brown = 1'b0;
    logic       evt_wdog = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdog_flag;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_q = 4'h1;

    reset_cause_reg u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .evt_ext   (evt_ext),
        .evt_brown (evt_brown),
        .evt_wdog  (evt_wdog),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wdog_flag (wdog_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model_next(input logic [3:0] cur, input logic we,
                                              input logic [7:0] wd, input logic e_ext,
                                              input logic e_brn, input logic e_wd);
        logic [3:0] n;
        n = we ? (cur & wd[3:0]) : cur;
        n = n | {e_wd, e_brn, e_ext, 1'b0};
        return n;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] wd, input logic e_ext,
                        input logic e_brn, input logic e_wd, input string tag);
        wr_en = we; wr_data = wd; evt_ext = e_ext; evt_brown = e_brn; evt_wdog = e_wd;
        exp_q = model_next(exp_q, we, wd, e_ext, e_brn, e_wd);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; evt_ext = 1'b0; evt_brown = 1'b0; evt_wdog = 1'b0;
        check(tag, rd_data, {4'h0, exp_q});
        check("R10 wdog pin", {7'h0, wdog_flag}, {7'h0, exp_q[3]});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        #(CLK_PERIOD * 2 + 1);
        // R1 value during power-on
        check("R1 por active", rd_data, 8'h01);
        @(negedge clk);
        por_n = 1'b1;
        exp_q = 4'h1;
        @(negedge clk);
        check("R1 after release", rd_data, 8'h01);

        // R3 each cause lands on its bit position
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R5 clear all");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R3 R4 ext bit1");
        check("R3 ext pos", rd_data, 8'h02);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3 R4 brown bit2");
        check("R3 brown pos", rd_data, 8'h06);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R3 R4 wdog bit3");
        check("R3 wdog pos", rd_data, 8'h0E);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 hold");
        // R6 ones keep, R2 reserved stays zero
        step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, "R6 write ones");
        check("R2 reserved", rd_data & 8'hF0, 8'h00);
        // R7 set beats clear
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R7 set wins");
        check("R7 brown kept", rd_data, 8'h04);
        // R8 pulses never set power-on flag
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R8 no pwr set");
        check("R8 pwr bit", {7'h0, rd_data[0]}, 8'h00);

        // R1 mid-run power-on clears others
        @(negedge clk);
        por_n = 1'b0;
        #1;
        check("R1 async load", rd_data, 8'h01);
        @(negedge clk);
        por_n = 1'b1;
        exp_q = 4'h1;
        // R8 power-on flag cleared only by zero write
        step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 one keeps pwr");
        step(1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, "R8 zero clears pwr");

        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic we;
            logic [7:0] wd;
            we = ($urandom % 3) == 0;
            wd = 8'($urandom);
            step(we, wd, ($urandom % 7) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0,
                 "R4 R5 R6 R7 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule